// File: doc/BRIEF.md
# Circular Receive Buffer Writer

This block sits between a byte-wide receive queue on the system clock side and a shared single-port word memory. Each received byte is placed in the next free byte lane of a 32-bit holding word. A full word is stored at the current write position of a circular region of the memory. Firmware sets the region with two byte offsets: a start and an end. It drains the data by moving a read pointer.

The write pointer has a byte offset within the region plus one extra phase bit. The phase bit flips every time the pointer wraps from the end word back to the start word. Comparing the two pointers gives full and empty status, a byte fill level, a level interrupt and a full interrupt. While the region is full, the block stops taking bytes from the receive queue, so nothing is lost.

When bytes stop arriving and the holding word is only partly filled, an idle counter runs. At the end of a programmable wait, the partial word is stored with its unused lanes set to zero. Later bytes keep filling the same word, which is then stored again once it is complete. The reset values of the configuration live in the package as constants, for use by the register file that drives the configuration inputs.

Top module: `rxw_sram_writer`

## Requirements
- R1: Bytes are packed little-endian: the first byte of a word goes to bits 7:0, the fourth to bits 31:24. Each completed word causes exactly one memory write, and the write pointer advances by 4.
- R2: The memory word address is the start word plus the pointer's word offset. The start and end offsets are byte offsets whose low 2 bits are ignored, and no write falls outside the start..end word window.
- R3: `wr_ptr` bits 10:0 hold the byte offset from the start of the region, and bit 11 holds the phase. Advancing past the end word returns the offset to 0 and toggles the phase.
- R4: Suppose the holding word has valid bytes and the input queue stays empty for T+1 consecutive cycles, where T is `cfg_idle`. Then the partial word is written with its unfilled lanes set to zero, and the pointer advances by the number of valid bytes.
- R5: Bytes that arrive after a partial flush fill the remaining lanes of the same word. The complete word, including the earlier bytes, is then written again to the same address.
- R6: The region is full when the word offsets of `wr_ptr` and `rd_ptr` match and their phases differ. While full, `st_full` is 1 and `in_pop` stays 0. Popping resumes once `rd_ptr` moves on.
- R7: The region is empty when both the word offsets and the phases match. `st_empty` is 1 out of reset.
- R8: `irq_lvl` is 1 when the byte fill level is strictly greater than `cfg_lvl`. The fill level is (wr − rd) when the phases are equal, and (region bytes − rd + wr) when they differ.
- R9: `irq_full` is a one-cycle pulse on each transition into the full state.
- R10: After reset, there is no memory write, `wr_ptr` is 0, `st_empty` is 1, and `st_full`, `irq_lvl` and `irq_full` are 0. `in_pop` is only asserted while `in_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_empty | input | 1 | Receive queue has no byte |
| in_data | input | 8 | Head byte of the receive queue (show-ahead) |
| in_pop | output | 1 | Take the head byte this cycle |
| cfg_base | input | 16 | Region start byte offset (low 2 bits ignored) |
| cfg_limit | input | 16 | Region end byte offset (low 2 bits ignored) |
| cfg_idle | input | 8 | Idle wait before a partial word is flushed |
| cfg_lvl | input | 16 | Fill-level threshold in bytes |
| rd_ptr | input | 16 | Firmware read pointer: phase at bit 11, byte offset in 10:0 |
| wr_ptr | output | 16 | Write pointer, same format |
| sram_we | output | 1 | Memory write strobe |
| sram_addr | output | 9 | Memory word address |
| sram_wdata | output | 32 | Memory write data |
| st_full | output | 1 | Region full |
| st_empty | output | 1 | Region empty |
| irq_lvl | output | 1 | Fill level above threshold |
| irq_full | output | 1 | Pulse on becoming full |

## Verification
The properties assume that the start offset is not above the end offset, and that the configuration changes only while reset is held. The window check relies on this. They also assume that the receive queue keeps its head byte until it is popped. The bench applies every start and end offset during reset. It keeps the read pointer inside the active region. Its queue model advances only on a popped cycle, so these assumptions hold for every scenario.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  // Reset values of the configuration that drives this block
  localparam logic [15:0] RST_BASE  = 16'h0000;
  localparam logic [15:0] RST_LIMIT = 16'h01FC;
  localparam logic [7:0]  RST_IDLE  = 8'h7F;
  localparam logic [15:0] RST_LVL   = 16'h0080;
endpackage

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxw_wptr.sv
module rxw_wptr #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic [LANE_W:0]        adv_n,
  input  logic [ADDR_W-1:0]      span_last,
  output logic [ADDR_W+LANE_W:0] ptr
);
  localparam int unsigned OFF_W = ADDR_W + LANE_W;

  logic              phase_q;
  logic [ADDR_W-1:0] wofs_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W:0]   lane_sum;

  assign lane_sum = {1'b0, lane_q} + adv_n;
  assign ptr      = {phase_q, wofs_q, lane_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      wofs_q  <= '0;
      lane_q  <= '0;
    end else if (adv) begin
      if (lane_sum[LANE_W]) begin
        lane_q <= '0;
        if (wofs_q == span_last) begin
          wofs_q  <= '0;
          phase_q <= ~phase_q;
        end else begin
          wofs_q <= wofs_q + 1'b1;
        end
      end else begin
        lane_q <= lane_sum[LANE_W-1:0];
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{OFF_W};
endmodule

// File: rtl/rxw_status.sv
module rxw_status #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned LVL_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W+LANE_W:0] wptr,
  input  logic [ADDR_W+LANE_W:0] rptr,
  input  logic [ADDR_W-1:0]      span_last,
  input  logic [LVL_W-1:0]       lvl_thr,
  output logic                   full_now,
  output logic                   st_full,
  output logic                   st_empty,
  output logic                   irq_lvl,
  output logic                   irq_full
);
  localparam int unsigned OFF_W = ADDR_W + LANE_W;

  logic             same_word, ph_diff, empty_now;
  logic [LVL_W-1:0] woff, roff, size_b, level;

  assign same_word = wptr[OFF_W-1:LANE_W] == rptr[OFF_W-1:LANE_W];
  assign ph_diff   = wptr[OFF_W] ^ rptr[OFF_W];
  assign full_now  = same_word && ph_diff;
  assign empty_now = same_word && !ph_diff;

  assign woff   = LVL_W'(wptr[OFF_W-1:0]);
  assign roff   = LVL_W'(rptr[OFF_W-1:0]);
  assign size_b = LVL_W'(({1'b0, span_last} + 1'b1)) << LANE_W;
  assign level  = ph_diff ? (size_b - roff + woff) : (woff - roff);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_full  <= 1'b0;
      st_empty <= 1'b1;
      irq_lvl  <= 1'b0;
      irq_full <= 1'b0;
    end else begin
      st_full  <= full_now;
      st_empty <= empty_now;
      irq_lvl  <= level > lvl_thr;
      irq_full <= full_now && !st_full;
    end
  end
endmodule

// File: rtl/rxw_sram_writer.sv
module rxw_sram_writer #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PTR_W      = 16,
  parameter int unsigned IDLE_W     = 8,
  parameter int unsigned LVL_W      = 16,
  localparam int unsigned DW        = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_empty,
  input  logic [7:0]        in_data,
  output logic              in_pop,
  input  logic [PTR_W-1:0]  cfg_base,
  input  logic [PTR_W-1:0]  cfg_limit,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [LVL_W-1:0]  cfg_lvl,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DW-1:0]     sram_wdata,
  output logic              st_full,
  output logic              st_empty,
  output logic              irq_lvl,
  output logic              irq_full
);
  localparam int unsigned LANE_W = $clog2(WORD_BYTES);
  localparam int unsigned OFF_W  = ADDR_W + LANE_W;
  localparam int unsigned CNT_W  = LANE_W + 1;

  logic [ADDR_W-1:0] base_w, limit_w, span_last, cur_addr;
  logic [OFF_W:0]    ptr, rptr;
  logic [LANE_W-1:0] ptr_lane;
  logic [CNT_W-1:0]  cnt_q, lane_sum, adv_n;
  logic [DW-1:0]     hold_q, hold_ins;
  logic              full_now, word_done, flush, adv, idle_run;

  assign base_w    = cfg_base[OFF_W-1:LANE_W];
  assign limit_w   = cfg_limit[OFF_W-1:LANE_W];
  assign span_last = limit_w - base_w;
  assign rptr      = rd_ptr[OFF_W:0];
  assign wr_ptr    = PTR_W'(ptr);
  assign ptr_lane  = ptr[LANE_W-1:0];
  assign cur_addr  = base_w + ptr[OFF_W-1:LANE_W];

  // byte intake and lane placement
  assign in_pop    = !in_empty && !full_now;
  assign lane_sum  = {1'b0, ptr_lane} + cnt_q;
  assign word_done = in_pop && (lane_sum == CNT_W'(WORD_BYTES - 1));

  always_comb begin
    hold_ins = hold_q;
    hold_ins[{lane_sum[LANE_W-1:0], 3'b000} +: 8] = in_data;
  end

  // partial-word flush after an idle stretch
  assign idle_run = (cnt_q != '0) && in_empty && !full_now;

  rxw_idle_timer #(.CNT_W(IDLE_W)) idle_i (
    .clk    (clk),
    .rst    (rst),
    .run    (idle_run),
    .limit  (cfg_idle),
    .expire (flush)
  );

  assign adv   = word_done || flush;
  assign adv_n = word_done ? cnt_q + 1'b1 : cnt_q;

  rxw_wptr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) wptr_i (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .adv_n     (adv_n),
    .span_last (span_last),
    .ptr       (ptr)
  );

  rxw_status #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LVL_W(LVL_W)) stat_i (
    .clk       (clk),
    .rst       (rst),
    .wptr      (ptr),
    .rptr      (rptr),
    .span_last (span_last),
    .lvl_thr   (cfg_lvl),
    .full_now  (full_now),
    .st_full   (st_full),
    .st_empty  (st_empty),
    .irq_lvl   (irq_lvl),
    .irq_full  (irq_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      hold_q     <= '0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      sram_we <= 1'b0;
      if (in_pop) begin
        if (word_done) begin
          sram_we    <= 1'b1;
          sram_addr  <= cur_addr;
          sram_wdata <= hold_ins;
          hold_q     <= '0;
          cnt_q      <= '0;
        end else begin
          hold_q <= hold_ins;
          cnt_q  <= cnt_q + 1'b1;
        end
      end else if (flush) begin
        sram_we    <= 1'b1;
        sram_addr  <= cur_addr;
        sram_wdata <= hold_q;
        cnt_q      <= '0;
      end
    end
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg_base, cfg_limit, rd_ptr};
endmodule

// File: rtl/rxw_sram_writer_chk.sv
module rxw_sram_writer_chk #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PTR_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_empty,
  input logic              in_pop,
  input logic [PTR_W-1:0]  cfg_base,
  input logic [PTR_W-1:0]  cfg_limit,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              sram_we,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              st_full,
  input logic              st_empty,
  input logic              irq_full
);
  localparam int unsigned LANE_W = $clog2(WORD_BYTES);
  localparam int unsigned OFF_W  = ADDR_W + LANE_W;

  logic [ADDR_W-1:0] lo_w, hi_w;
  assign lo_w = cfg_base[OFF_W-1:LANE_W];
  assign hi_w = cfg_limit[OFF_W-1:LANE_W];

  // R10
  pop_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    in_pop |-> !in_empty);

  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_full && st_empty));

  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (sram_addr >= lo_w) && (sram_addr <= hi_w));

  // R3
  ptr_moves_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_ptr) |-> sram_we);

  // R9
  full_irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> st_full && !$past(st_full));

  logic unused_chk;
  assign unused_chk = ^{cfg_base, cfg_limit};
endmodule

bind rxw_sram_writer rxw_sram_writer_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .PTR_W(PTR_W)
) chk_i (
  .clk(clk), .rst(rst), .in_empty(in_empty), .in_pop(in_pop),
  .cfg_base(cfg_base), .cfg_limit(cfg_limit), .wr_ptr(wr_ptr),
  .sram_we(sram_we), .sram_addr(sram_addr), .st_full(st_full),
  .st_empty(st_empty), .irq_full(irq_full)
);

// File: tb/rxw_sram_writer_tb_top.sv
`timescale 1ns/1ps
module rxw_sram_writer_tb_top;
  import rxw_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_empty, in_pop;
  logic [7:0]  in_data;
  logic [15:0] cfg_base = RST_BASE, cfg_limit = RST_LIMIT, cfg_lvl = RST_LVL;
  logic [7:0]  cfg_idle = RST_IDLE;
  logic [15:0] rd_ptr = 16'h0, wr_ptr;
  logic        sram_we, st_full, st_empty, irq_lvl, irq_full;
  logic [8:0]  sram_addr;
  logic [31:0] sram_wdata;

  always #2 clk = ~clk;

  // receive queue model
  logic [7:0] q [0:63];
  int n_push = 0;
  int idx = 0;
  logic pop_s = 1'b0;
  assign in_empty = (idx >= n_push);
  assign in_data  = q[idx[5:0]];

  // memory model and monitors
  logic [31:0] mem [0:511];
  int wcount = 0, idle_cnt = 0, last_idle = 0, full_pulses = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  rxw_sram_writer dut_i (
    .clk(clk), .rst(rst), .in_empty(in_empty), .in_data(in_data), .in_pop(in_pop),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_idle(cfg_idle), .cfg_lvl(cfg_lvl),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .st_full(st_full), .st_empty(st_empty),
    .irq_lvl(irq_lvl), .irq_full(irq_full)
  );

  always @(negedge clk) begin
    pop_s <= in_pop && !rst;
    if (!rst) begin
      if (sram_we) begin
        mem[sram_addr] = sram_wdata;
        wcount++;
        last_idle = idle_cnt;
      end
      if (irq_full) full_pulses++;
      if (in_pop) idle_cnt = 0;
      else        idle_cnt++;
    end
  end

  always @(posedge clk) begin
    if (rst)        idx <= 0;
    else if (pop_s) idx <= idx + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    q[n_push[5:0]] = b;
    n_push++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    n_push = 0;
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    cycles(3);
    wcount = 0;
    full_pulses = 0;
    rst = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "sram_we",  {31'b0, sram_we},  32'h0);
    chk("R10", "wr_ptr",   {16'h0, wr_ptr},   32'h0);
    chk("R7",  "st_empty", {31'b0, st_empty}, 32'h1);
    chk("R10", "st_full",  {31'b0, st_full},  32'h0);
    chk("R10", "irqs",     {30'b0, irq_lvl, irq_full}, 32'h0);
  endtask

  task automatic t_pack();
    for (int i = 1; i <= 8; i++) push(8'(i));
    cycles(12);
    chk("R1", "word0", mem[0], 32'h04030201);
    chk("R1", "word1", mem[1], 32'h08070605);
    chk("R1", "writes", wcount, 2);
    chk("R1", "wr_ptr", {16'h0, wr_ptr}, 32'h8);
  endtask

  task automatic t_partial();
    cfg_idle = 8'd20;
    push(8'hAA); push(8'hBB);
    cycles(40);
    chk("R4", "flush word", mem[2], 32'h0000BBAA);
    chk("R4", "idle cycles", last_idle, 21);
    chk("R4", "wr_ptr", {16'h0, wr_ptr}, 32'hA);
    push(8'hCC); push(8'hDD);
    cycles(6);
    chk("R5", "merged word", mem[2], 32'hDDCCBBAA);
    chk("R5", "wr_ptr", {16'h0, wr_ptr}, 32'hC);
    chk("R5", "writes", wcount, 4);
    cfg_idle = RST_IDLE;
  endtask

  task automatic t_full_wrap();
    cfg_base = 16'h0103; cfg_limit = 16'h010C; rd_ptr = 16'h0;
    do_reset();
    for (int i = 0; i < 16; i++) push(8'(8'h10 + i));
    cycles(24);
    chk("R2", "first word", mem[9'h40], 32'h13121110);
    chk("R2", "last word",  mem[9'h43], 32'h1F1E1D1C);
    chk("R2", "outside",    mem[9'h44] | mem[9'h3F], 32'h0);
    chk("R3", "wrap ptr",   {16'h0, wr_ptr}, 32'h800);
    chk("R6", "st_full",    {31'b0, st_full}, 32'h1);
    chk("R9", "pulses",     full_pulses, 1);
    for (int i = 0; i < 4; i++) push(8'(8'hA0 + i));
    cycles(20);
    chk("R6", "no pop while full", idx, 16);
    chk("R6", "no write while full", wcount, 4);
    rd_ptr = 16'h0004;
    cycles(10);
    chk("R6", "resumed", idx, 20);
    chk("R3", "overwrite start", mem[9'h40], 32'hA3A2A1A0);
    chk("R3", "ptr after wrap", {16'h0, wr_ptr}, 32'h804);
    chk("R9", "second pulse", full_pulses, 2);
    cfg_base = RST_BASE; cfg_limit = RST_LIMIT; rd_ptr = 16'h0;
  endtask

  task automatic t_level();
    cfg_lvl = 16'd10;
    do_reset();
    for (int i = 0; i < 8; i++) push(8'(i));
    cycles(12);
    chk("R8", "level 8 vs 10", {31'b0, irq_lvl}, 32'h0);
    chk("R7", "not empty", {31'b0, st_empty}, 32'h0);
    for (int i = 0; i < 4; i++) push(8'(i));
    cycles(8);
    chk("R8", "level 12 vs 10", {31'b0, irq_lvl}, 32'h1);
    cfg_lvl = 16'd12;
    cycles(3);
    chk("R8", "level 12 vs 12", {31'b0, irq_lvl}, 32'h0);
    rd_ptr = 16'd12;
    cycles(3);
    chk("R7", "empty again", {31'b0, st_empty}, 32'h1);
    cfg_lvl = RST_LVL; rd_ptr = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pack();
    t_partial();
    t_full_wrap();
    t_level();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule